// File: doc/BRIEF.md
# Armed One-Shot Capture Buffer

This block records a stream of decimated I/Q samples into an on-chip memory when a trigger arrives. Each sample is one packed word, with I and Q side by side. Software first arms the block with a length counted in transfers. A transfer is a fixed group of samples whose size is set by a parameter. The first trigger seen after arming starts a recording of exactly that many transfers into consecutive addresses from zero. When the recording ends, the block returns to idle and raises a done flag. All further triggers are ignored until the block is armed again.

Several options change how a recording behaves:
- **Overwrite:** when the enable is set, a length larger than the memory lets the write address wrap to zero. Without the enable, such a length is refused and flagged as an error.
- **Fill mode:** a parameter selects a variant in which a trigger fills the whole memory and the length input is ignored.
- **Clear:** a command writes zeros through the memory. Busy stays high for the whole sweep.

A registered read port returns stored words. A constant output tells readers how many leading entries of a capture to treat as stale.

Top module: `capture_buf`

## Requirements
- R1: After reset, armed, busy, done and err are all 0, and stale_skip equals the STALE parameter.
- R2: While the block is not armed, a trigger neither raises busy nor writes the memory.
- R3: An arm request with length L (1 ≤ L·SPX ≤ capacity) raises armed on the next cycle. A capture then writes exactly L·SPX samples to addresses 0 upward and leaves later addresses untouched.
- R4: Only the first trigger after arming starts a capture. A trigger during or after the capture is ignored until the block is re-armed.
- R5: When arm and trigger are both high in the same cycle of the armed state, the trigger is ignored and the block stays armed.
- R6: The write of the last sample happens on clock edge k. After edge k, busy is low and done is high; before edge k, busy is high and done is low. A new arm or clear drops done.
- R7: An arm with L = 0, or with L·SPX above capacity while overwrite is 0, leaves the block unarmed and raises err.
- R8: With overwrite = 1, a length above capacity is accepted. Sample n is written to address n mod capacity, so later samples replace earlier ones.
- R9: With FILL_MODE = 1, a trigger after arming records exactly capacity samples, whatever the length input holds.
- R10: A clear command holds busy high for exactly capacity cycles after it is taken, and leaves every memory word at zero.
- R11: rd_data shows the word at rd_addr one clock after rd_addr is applied.
- R12: Only samples that arrive with in_valid high, on cycles after the trigger cycle, are recorded. The sample that arrives with the trigger is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm request pulse |
| len_xfers | input | LEN_W | Recording length in transfers |
| overwrite | input | 1 | Allow the write address to wrap |
| clear | input | 1 | Zero-fill command pulse |
| trig | input | 1 | Capture trigger |
| in_valid | input | 1 | Sample valid |
| in_data | input | DATA_W | Packed I/Q sample |
| rd_addr | input | log2(SPX·DEPTH_XFERS) | Read address |
| rd_data | output | DATA_W | Registered read data |
| armed | output | 1 | Waiting for a trigger |
| busy | output | 1 | Capturing or clearing |
| done | output | 1 | Last capture completed |
| err | output | 1 | Last arm request refused |
| stale_skip | output | log2(SPX·DEPTH_XFERS) | Count of leading stale entries |

## Verification
An arm request and a trigger can land in the same cycle while the block is armed. The bench drives both high on one edge and then checks two things: busy stays low and armed stays high. A later separate trigger then starts a normal capture. Two more collisions are provoked on purpose:
- The sample presented on the trigger cycle must not appear in memory.
- The last write and the done flag must meet on one edge. The bench samples busy and done on each side of that edge.

// File: rtl/capture_buf.sv
module capture_buf #(
  parameter int DATA_W      = 32,
  parameter int SPX         = 128,
  parameter int DEPTH_XFERS = 8,
  parameter int LEN_W       = 16,
  parameter int STALE       = 8,
  parameter bit FILL_MODE   = 1'b0,
  localparam int DEPTH      = SPX * DEPTH_XFERS,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LEN_W-1:0]  len_xfers,
  input  logic              overwrite,
  input  logic              clear,
  input  logic              trig,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              armed,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [AW-1:0]     stale_skip
);
  localparam int SW = $clog2(SPX);
  localparam int TW = LEN_W + SW + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_CAP, S_CLR} st_t;
  st_t st;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr;
  logic [TW-1:0]     target, cnt;

  wire [TW-1:0] req_len = TW'(len_xfers) << SW;
  wire refuse  = !FILL_MODE && ((len_xfers == '0) || (!overwrite && req_len > TW'(DEPTH)));
  wire wr_en   = (st == S_CAP && in_valid) || st == S_CLR;
  wire [DATA_W-1:0] wr_d = (st == S_CLR) ? '0 : in_data;

  assign armed      = (st == S_ARM);
  assign busy       = (st == S_CAP) || (st == S_CLR);
  assign stale_skip = AW'(STALE);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_d;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wptr   <= '0;
      cnt    <= '0;
      target <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_ARM: begin
          if (clear) begin
            st   <= S_CLR;
            wptr <= '0;
            done <= 1'b0;
            err  <= 1'b0;
          end else if (arm) begin
            done <= 1'b0;
            if (refuse) begin
              st  <= S_IDLE;
              err <= 1'b1;
            end else begin
              st     <= S_ARM;
              err    <= 1'b0;
              target <= FILL_MODE ? TW'(DEPTH) : req_len;
            end
          end else if (st == S_ARM && trig) begin
            st   <= S_CAP;
            wptr <= '0;
            cnt  <= '0;
          end
        end
        S_CAP: begin
          if (in_valid) begin
            wptr <= wptr + 1'b1;
            cnt  <= cnt + 1'b1;
            if (cnt == target - TW'(1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        S_CLR: begin
          wptr <= wptr + 1'b1;
          if (wptr == AW'(DEPTH - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/capture_buf_chk.sv
module capture_buf_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic trig,
  input logic clear,
  input logic armed,
  input logic busy,
  input logic done,
  input logic err
);
  AST_NO_RECORD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n) (!armed && !busy && !clear) |=> !busy); // R2
  AST_ARM_BEATS_TRIG: assert property (@(posedge clk) disable iff (!rst_n) (armed && arm && trig && !clear) |=> (armed && !busy)); // R5
  AST_DONE_MEETS_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $fell(busy)); // R6
  AST_ERR_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n) err |-> !armed); // R7
  AST_NO_REARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && trig) |=> !armed); // R4
  AST_BUSY_ARMED_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && armed)); // R3
endmodule

bind capture_buf capture_buf_chk u_chk (.*);

// File: tb/sim_capture_buf.sv
module sim_capture_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic arm = 0, arm1 = 0, trig = 0, trig1 = 0, clear = 0, overwrite = 0, in_valid = 0;
  logic [3:0]  len_xfers = '0, rd_addr = '0;
  logic [31:0] in_data = '0, rd0, rd1;
  logic armed0, busy0, done0, err0, armed1, busy1, done1, err1;
  logic [3:0] stale0, stale1;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_buf #(.DATA_W(32), .SPX(4), .DEPTH_XFERS(4), .LEN_W(4), .STALE(2), .FILL_MODE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .len_xfers(len_xfers), .overwrite(overwrite), .clear(clear),
    .trig(trig), .in_valid(in_valid), .in_data(in_data), .rd_addr(rd_addr), .rd_data(rd0),
    .armed(armed0), .busy(busy0), .done(done0), .err(err0), .stale_skip(stale0));

  capture_buf #(.DATA_W(32), .SPX(4), .DEPTH_XFERS(4), .LEN_W(4), .STALE(2), .FILL_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .arm(arm1), .len_xfers(len_xfers), .overwrite(overwrite), .clear(clear),
    .trig(trig1), .in_valid(in_valid), .in_data(in_data), .rd_addr(rd_addr), .rd_data(rd1),
    .armed(armed1), .busy(busy1), .done(done1), .err(err1), .stale_skip(stale1));

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp0 [DEPTH];
  logic [31:0] exp1 [DEPTH];

  typedef struct { logic [31:0] exp; string req; int stamp; bit unit; int addr; } item_t;
  item_t q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].stamp < cyc) begin
      item_t it = q.pop_front();
      logic [31:0] got = it.unit ? rd1 : rd0;
      chk(got === it.exp, it.req, got, it.exp);
    end
  end

  task automatic rd_push(bit u, int a, logic [31:0] e, string req);
    @(negedge clk);
    rd_addr = 4'(a);
    q.push_back('{e, req, cyc, u, a});
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_arm(bit u, int len, bit ow);
    @(negedge clk);
    len_xfers = 4'(len); overwrite = ow;
    if (u) arm1 = 1; else arm = 1;
    @(negedge clk);
    arm = 0; arm1 = 0;
  endtask

  task automatic run_cap(bit u, int tgt, logic [31:0] seed, string req);
    int wc = 0;
    int i = 0;
    @(negedge clk);
    if (u) trig1 = 1; else trig = 1;
    in_valid = 1; in_data = 32'hDEAD_BEEF;
    @(negedge clk);
    trig = 0; trig1 = 0;
    while (wc < tgt) begin
      in_valid = (i % 4) != 3;
      in_data  = seed + 32'(i);
      if (in_valid) begin
        if (u) exp1[wc % DEPTH] = in_data; else exp0[wc % DEPTH] = in_data;
        wc++;
        if (wc == tgt) begin
          chk((u ? busy1 : busy0) === 1'b1, {req, " R6 busy before last write"}, u ? busy1 : busy0, 1);
          chk((u ? done1 : done0) === 1'b0, {req, " R6 done before last write"}, u ? done1 : done0, 0);
        end
      end
      i++;
      @(negedge clk);
    end
    in_valid = 0;
    chk((u ? busy1 : busy0) === 1'b0, {req, " R6 busy after last write"}, u ? busy1 : busy0, 0);
    chk((u ? done1 : done0) === 1'b1, {req, " R6 done after last write"}, u ? done1 : done0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({armed0, busy0, done0, err0} === 4'b0, "R1 flags", {armed0, busy0, done0, err0}, 0);
    chk(stale0 === 4'd2, "R1 stale_skip", stale0, 2);

    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    chk(busy0 === 1'b1, "R10 busy start", busy0, 1);
    repeat (15) @(negedge clk);
    chk(busy0 === 1'b1, "R10 busy last clear cycle", busy0, 1);
    @(negedge clk);
    chk(busy0 === 1'b0, "R10 busy end", busy0, 0);
    for (int k = 0; k < DEPTH; k++) begin exp0[k] = '0; exp1[k] = '0; end
    rd_push(0, 5, 32'h0, "R10 zero word");
    rd_push(0, 15, 32'h0, "R10 zero last word");
    drain();

    @(negedge clk); trig = 1; in_valid = 1; in_data = 32'h55;
    @(negedge clk); trig = 0;
    @(negedge clk); in_valid = 0;
    chk(busy0 === 1'b0, "R2 trigger unarmed busy", busy0, 0);
    rd_push(0, 0, 32'h0, "R2 memory untouched");
    drain();

    pulse_arm(0, 5, 0);
    chk(err0 === 1'b1 && armed0 === 1'b0, "R7 oversize refused", {err0, armed0}, 2);
    pulse_arm(0, 0, 1);
    chk(err0 === 1'b1 && armed0 === 1'b0, "R7 zero length refused", {err0, armed0}, 2);

    pulse_arm(0, 2, 0);
    chk(armed0 === 1'b1 && err0 === 1'b0, "R3 armed", {armed0, err0}, 2);
    @(negedge clk); arm = 1; trig = 1;
    @(negedge clk); arm = 0; trig = 0;
    chk(armed0 === 1'b1 && busy0 === 1'b0, "R5 arm and trigger together", {armed0, busy0}, 2);

    run_cap(0, 8, 32'h1000, "R3 capture");
    for (int k = 0; k < 8; k++) rd_push(0, k, exp0[k], "R3 R12 captured word");
    rd_push(0, 8, 32'h0, "R3 beyond length untouched");
    drain();

    @(negedge clk); trig = 1; in_valid = 1; in_data = 32'h77;
    @(negedge clk); trig = 0;
    @(negedge clk); in_valid = 0;
    chk(busy0 === 1'b0, "R4 late trigger busy", busy0, 0);
    chk(done0 === 1'b1, "R4 done kept", done0, 1);
    rd_push(0, 0, exp0[0], "R4 late trigger no write");
    drain();

    pulse_arm(0, 5, 1);
    chk(armed0 === 1'b1 && done0 === 1'b0, "R6 R8 rearm clears done", {armed0, done0}, 2);
    run_cap(0, 20, 32'h2000, "R8 wrap capture");
    for (int k = 0; k < DEPTH; k++) rd_push(0, k, exp0[k], "R8 wrapped word");
    drain();

    pulse_arm(1, 1, 0);
    chk(armed1 === 1'b1, "R9 fill armed", armed1, 1);
    run_cap(1, DEPTH, 32'h3000, "R9 fill capture");
    for (int k = 0; k < DEPTH; k += 5) rd_push(1, k, exp1[k], "R9 R11 fill word");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule